// File: doc/BRIEF.md
# Conversion-Capture Queue with Direct Path

This block sits between a sampling engine and a chip output register. Every completed conversion arrives as an 18-bit word on a one-cycle strobe. The low 16 bits are the result, bit 16 is the inverted-MSB copy and bit 17 is the overflow flag. The block passes each word through unchanged. A path-select input chooses one of two routes. In direct mode each word goes straight to the output register. In queue mode up to 16 words are held in arrival order. The oldest held word is always shown on the output. Each rising edge of an active-low read line steps the output to the next word.

Two fill-state pins report whether the queue is empty, partly filled or full. The queue can be cleared to empty from the pins at any time. The read line, path select and output enable arrive from outside the clock domain, so each passes through a two-flop synchronizer. The output enable is active low. It drives a drive-enable signal for the pad-level three-state buffer.

Top module: `conv_capture_fifo`

## Requirements
- R1: After reset the data output is all zeros, fill_a=0 and fill_b=1 (empty), and bus_oe=0.
- R2: With path_sel low (direct), each conversion strobe loads its word onto bus_data one clock later. The queue contents and fill pins are left as they were. When path_sel returns high with words still held, the oldest held word is put back on bus_data.
- R3: With path_sel high, every conversion strobe writes its word into the queue whatever the level of rd_n. The queue holds at most 16 words.
- R4: A word written into an empty queue appears on bus_data one clock after its strobe. It stays there until a read step occurs.
- R5: Each rising edge of rd_n moves bus_data to the next held word, in arrival order. Fifteen rising edges walk a full queue from the first word to the sixteenth.
- R6: A conversion strobe that arrives while the queue holds 16 words, judged on the occupancy before that cycle, is discarded. So is every later strobe until space is freed.
- R7: A rising edge of rd_n while one word is held removes that word and leaves the queue empty. A rising edge while the queue is empty does nothing. In both cases bus_data keeps its value.
- R8: Holding path_sel low and rd_n low together clears the queue to empty.
- R9: The fill pins encode the state as {fill_a, fill_b}: empty = 01, 1 to 15 words = 00, 16 words = 11. The code 10 never appears.
- R10: bus_oe is high only while out_en_n is low, following it through a two-flop synchronizer.
- R11: Asynchronous inputs pass two synchronizer flops. A rising edge of rd_n takes effect on the third clock edge after it. A read edge and a conversion strobe that take effect in the same cycle are handled together as one read and one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnv_valid | input | 1 | One-cycle strobe: a conversion word is ready (clock domain) |
| cnv_word | input | 18 | Conversion word: [15:0] result, [16] inverted MSB, [17] overflow |
| path_sel | input | 1 | 1 = queue path, 0 = direct path (asynchronous) |
| rd_n | input | 1 | Active-low read line; a rising edge steps the queue (asynchronous) |
| out_en_n | input | 1 | Active-low output enable (asynchronous) |
| bus_data | output | 18 | Output register contents |
| bus_oe | output | 1 | Drive enable for the pad three-state buffer |
| fill_a | output | 1 | Fill code, high bit |
| fill_b | output | 1 | Fill code, low bit |

## Verification
The assertions assume that cnv_valid is a single-cycle pulse in the clock domain. They also assume that rd_n and path_sel hold each level long enough to pass the synchronizer, at least three clocks, and that the read line is not held low in direct mode unless a clear is intended. The bench changes asynchronous inputs only on the falling clock edge and then waits four clocks before the next change. Conversion strobes are always one cycle wide. The single simultaneous read-and-write case is placed so that the strobe lands in the exact cycle the synchronized read edge is live.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  localparam int unsigned WORD_W = 18;
  typedef enum logic [1:0] {
    FILL_PART  = 2'b00,
    FILL_EMPTY = 2'b01,
    FILL_FULL  = 2'b11
  } fill_code_e;
endpackage

// File: rtl/cfb_sync.sv
module cfb_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= RST_VAL;
      else        pipe_q[s] <= (s == 0) ? d : pipe_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cfb_queue.sv
module cfb_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 18,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  logic             mode_rise,
  input  logic             rd_edge,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_word,
  output logic [CNT_W-1:0] cnt,
  output logic             ld,
  output logic [W-1:0]     ld_word
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d, rp_nx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_w, empty_w, pop_w, push_w;

  assign full_w  = (cnt_q == FULL_CNT);
  assign empty_w = (cnt_q == '0);
  assign pop_w   = fifo_on && rd_edge && !mode_rise && !empty_w;
  assign push_w  = fifo_on && wr_en && !full_w;
  assign rp_nx   = rp_q + 1'b1;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_w) wp_d = wp_q + 1'b1;
      if (pop_w)  rp_d = rp_nx;
      case ({push_w, pop_w})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_w) mem_q[wp_q] <= wr_word;
  end

  // Output load selection: head reload on path return, step on read,
  // or a new word landing in an (effectively) empty queue.
  always_comb begin
    ld      = 1'b0;
    ld_word = mem_q[rp_q];
    if (mode_rise && !empty_w) begin
      ld = 1'b1;
    end else if (pop_w && (cnt_q > ONE_CNT)) begin
      ld      = 1'b1;
      ld_word = mem_q[rp_nx];
    end else if (push_w && (empty_w || pop_w)) begin
      ld      = 1'b1;
      ld_word = wr_word;
    end
  end

  assign cnt = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);                                            // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && wr_en && !pop_w) |=> $stable(wp_q));                // R6
  AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && !clr) |=> $stable(cnt_q));                        // R2
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));                                        // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_w && !wr_en && !clr) |=> (cnt_q == '0));                // R7
endmodule

// File: rtl/cfb_outreg.sv
module cfb_outreg #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_word,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (ld) q_d = ld_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q_q));                                         // R7
endmodule

// File: rtl/conv_capture_fifo.sv
module conv_capture_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = cfb_pkg::WORD_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_valid,
  input  logic [WORD_W-1:0] cnv_word,
  input  logic              path_sel,
  input  logic              rd_n,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              fill_a,
  output logic              fill_b
);
  import cfb_pkg::*;

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  logic [2:0]        ctl_s;
  logic              rd_s, mode_s, oe_s_n;
  logic              rd_d_q, mode_d_q;
  logic              rd_edge, mode_rise, clr;
  logic [CNT_W-1:0]  cnt;
  logic              q_ld, o_ld;
  logic [WORD_W-1:0] q_word, o_word;
  fill_code_e        fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  cfb_sync #(.W(3), .STAGES(2), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_s_n),
    .d({rd_n, path_sel, out_en_n}), .q(ctl_s)
  );
  assign {rd_s, mode_s, oe_s_n} = ctl_s;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rd_d_q   <= 1'b1;
      mode_d_q <= 1'b0;
    end else begin
      rd_d_q   <= rd_s;
      mode_d_q <= mode_s;
    end
  end

  assign rd_edge   = rd_s && !rd_d_q;
  assign mode_rise = mode_s && !mode_d_q;
  assign clr       = !mode_s && !rd_s;

  cfb_queue #(.DEPTH(DEPTH), .W(WORD_W)) u_queue (
    .clk(clk), .rst_n(rst_s_n),
    .fifo_on(mode_s), .mode_rise(mode_rise), .rd_edge(rd_edge), .clr(clr),
    .wr_en(cnv_valid), .wr_word(cnv_word),
    .cnt(cnt), .ld(q_ld), .ld_word(q_word)
  );

  assign o_ld   = mode_s ? q_ld   : cnv_valid;
  assign o_word = mode_s ? q_word : cnv_word;

  cfb_outreg #(.W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_s_n), .ld(o_ld), .ld_word(o_word), .q(bus_data)
  );

  always_comb begin
    if (cnt == '0)                 fill = FILL_EMPTY;
    else if (cnt == CNT_W'(DEPTH)) fill = FILL_FULL;
    else                           fill = FILL_PART;
  end
  assign {fill_a, fill_b} = fill;
  assign bus_oe = !oe_s_n;

  AST_FILL_LEGAL: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(fill_a && !fill_b));                                         // R9
  AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(bus_oe) |-> !$past(out_en_n));                           // R10
  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mode_s && cnv_valid) |=> (bus_data == $past(cnv_word)));     // R2
endmodule

// File: tb/tb_conv_capture_fifo.sv
module tb_conv_capture_fifo;
  logic        clk = 1'b0;
  logic        rst_n, cnv_valid, path_sel, rd_n, out_en_n;
  logic [17:0] cnv_word, bus_data;
  logic        bus_oe, fill_a, fill_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [17:0] mq[$];
  logic [17:0] m_out;
  bit          m_fifo;

  always #4 clk = ~clk;

  conv_capture_fifo dut (
    .clk(clk), .rst_n(rst_n), .cnv_valid(cnv_valid), .cnv_word(cnv_word),
    .path_sel(path_sel), .rd_n(rd_n), .out_en_n(out_en_n),
    .bus_data(bus_data), .bus_oe(bus_oe), .fill_a(fill_a), .fill_b(fill_b)
  );

  function automatic logic [1:0] exp_fill(int n);
    if (n == 0)       return 2'b01;
    else if (n == 16) return 2'b11;
    else              return 2'b00;
  endfunction

  // Reference step: read and/or write in one cycle (queue path).
  task automatic m_step(bit do_rd, bit do_wr, logic [17:0] w);
    int sz0 = mq.size();
    bit popped = 0;
    if (do_rd && sz0 > 0) begin void'(mq.pop_front()); popped = 1; end
    if (do_wr && sz0 < 16) mq.push_back(w);
    if (mq.size() > 0 && ((popped && sz0 >= 2) || (do_wr && (sz0 == 0 || (popped && sz0 == 1)))))
      m_out = mq[0];
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [17:0] exp_d, logic [1:0] exp_f);
    n_vec++;
    if (bus_data !== exp_d || {fill_a, fill_b} !== exp_f) begin
      n_bad++;
      $display("FAIL %s: data=%h fill=%b, expected data=%h fill=%b",
               req, bus_data, {fill_a, fill_b}, exp_d, exp_f);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b, expected %b", req, act, exp);
    end
  endtask

  task automatic conv(logic [17:0] w);
    cnv_valid = 1'b1; cnv_word = w;
    tick(1);
    cnv_valid = 1'b0;
    if (m_fifo) m_step(0, 1, w); else m_out = w;
  endtask

  task automatic read_step();
    rd_n = 1'b0; tick(4);
    rd_n = 1'b1; tick(4);
    if (m_fifo) m_step(1, 0, '0);
  endtask

  task automatic set_mode(bit v);
    path_sel = v; tick(4);
    if (v && !m_fifo && mq.size() > 0) m_out = mq[0];
    m_fifo = v;
  endtask

  // R11: read edge and strobe take effect in the same cycle.
  task automatic simul(logic [17:0] w);
    rd_n = 1'b0; tick(4);
    rd_n = 1'b1; tick(2);
    cnv_valid = 1'b1; cnv_word = w;
    tick(1);
    cnv_valid = 1'b0;
    m_step(1, 1, w);
    tick(2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cnv_valid = 1'b0; cnv_word = '0;
    path_sel = 1'b0; rd_n = 1'b1; out_en_n = 1'b1;
    m_out = '0; m_fifo = 0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    check("R1", 18'h0, 2'b01);
    check_bit("R1 oe", bus_oe, 1'b0);

    // R10 output enable
    out_en_n = 1'b0; tick(4);
    check_bit("R10 enable", bus_oe, 1'b1);
    out_en_n = 1'b1; tick(4);
    check_bit("R10 disable", bus_oe, 1'b0);

    // R2 direct path
    conv(18'h2A5A5);
    check("R2 direct", m_out, exp_fill(mq.size()));

    // R3/R4 first word appears immediately, read line low does not block writes
    set_mode(1);
    rd_n = 1'b0; tick(4);
    conv(18'h10001);
    check("R4 first word", m_out, exp_fill(mq.size()));
    conv(18'h10002);
    check("R3 write with rd low", m_out, exp_fill(mq.size()));
    rd_n = 1'b1; tick(4);
    m_step(1, 0, '0);
    check("R5 step", m_out, exp_fill(mq.size()));

    // R2 direct write leaves queue, path return restores head
    conv(18'h10003);
    set_mode(0);
    conv(18'h3FFFF);
    check("R2 queue untouched", m_out, exp_fill(mq.size()));
    set_mode(1);
    check("R2 head reload", m_out, exp_fill(mq.size()));

    // R8 clear
    set_mode(0);
    rd_n = 1'b0; tick(4);
    mq.delete();
    check("R8 clear", m_out, 2'b01);
    rd_n = 1'b1; tick(4);
    set_mode(1);

    // R6 fill to 16, drop extras, R5 drain with 15 edges, R7 last read
    for (int i = 0; i < 18; i++) begin
      conv(18'h20000 + 18'(i));
      check("R6 fill", m_out, exp_fill(mq.size()));
    end
    check("R9 full", 18'h20000, 2'b11);
    for (int i = 1; i < 16; i++) begin
      read_step();
      check("R5 drain", 18'h20000 + 18'(i), 2'b00);
    end
    read_step();
    check("R7 last read", 18'h2000F, 2'b01);
    read_step();
    check("R7 empty read", 18'h2000F, 2'b01);

    // R11 simultaneous read/write at one word and at full
    conv(18'h05555);
    simul(18'h0AAAA);
    check("R11 simul one", m_out, exp_fill(mq.size()));
    for (int i = 0; i < 15; i++) conv(18'h30000 + 18'(i));
    check("R9 full again", m_out, exp_fill(mq.size()));
    simul(18'h3ABCD);
    check("R11 simul full", m_out, exp_fill(mq.size()));

    // Random phase (queue path)
    for (int k = 0; k < 400; k++) begin
      int unsigned r = $urandom % 10;
      logic [17:0] w = 18'($urandom);
      if (r < 5)      begin conv(w);  check("R3 random write", m_out, exp_fill(mq.size())); end
      else if (r < 9) begin read_step(); check("R5 random read", m_out, exp_fill(mq.size())); end
      else            begin simul(w); check("R11 random simul", m_out, exp_fill(mq.size())); end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule